// File: doc/BRIEF.md
# Display RAM Address Counter

This block keeps the single address pointer that a character LCD controller uses for both its display text memory and its user glyph memory. A load command places an address in the counter and chooses which of the two memories later data transfers reach. After every data read or write the pointer steps by one in the direction set by the entry mode. Cursor moves step the pointer without any data transfer. Display shifts leave the pointer alone and move a scroll offset instead.

In the one-line layout the text memory is a single ring of 80 cells, 00h to 4Fh. In the two-line layout it holds two 40-cell rows, 00h to 27h and 40h to 67h, and stepping runs through them as one chain of 80 cells. The scroll offset is taken modulo the length of one visible line, so every line wraps within itself. The scan logic reads the pointer, the memory select and the offset.

Top module: `ram_addr_ctr`

## Requirements
- R1: While reset is applied, and after it is released, `addr_o` is 00h, `cg_sel_o` is 0 (text memory), `inc_o` is 1 and `shift_o` is 0.
- R2: A `ld_dd_i` pulse loads `ld_addr_i` into `addr_o` and sets `cg_sel_o` to 0.
- R3: A `ld_cg_i` pulse loads `ld_addr_i` into `addr_o` and sets `cg_sel_o` to 1.
- R4: A `mode_i` pulse copies `mode_inc_i` into `inc_o`. Each `acc_i` pulse then steps `addr_o` by +1 when `inc_o` is 1, or by -1 when it is 0.
- R5: In the one-line layout (`two_line_i`=0) with the text memory selected, stepping up from 4Fh gives 00h and stepping down from 00h gives 4Fh.
- R6: In the two-line layout with the text memory selected, stepping up goes 27h to 40h and 67h to 00h. Stepping down goes 40h to 27h and 00h to 67h.
- R7: With the glyph memory selected, stepping wraps modulo 128 (7Fh up to 00h, 00h down to 7Fh) and ignores the line layout.
- R8: A `move_i` pulse with `move_disp_i`=0 steps `addr_o` once under the R5–R7 rules: up when `move_right_i`=1, down otherwise. `shift_o` does not change.
- R9: A `move_i` pulse with `move_disp_i`=1 leaves `addr_o` and `cg_sel_o` unchanged. It adds 1 to `shift_o` when `move_right_i`=0 and subtracts 1 when `move_right_i`=1, modulo the line length (40 in two-line, 80 in one-line).
- R10: A `home_i` pulse sets `addr_o` to 00h, `shift_o` to 0 and `cg_sel_o` to 0, and leaves `inc_o` as it was.
- R11: A `clear_i` pulse does what `home_i` does and also sets `inc_o` to 1, even when `mode_i` is pulsed in the same cycle.
- R12: When several command strobes are high in one cycle, only one takes effect, in this priority order: `clear_i`, `home_i`, `ld_dd_i`, `ld_cg_i`, `move_i`, `acc_i`. A `mode_i` pulse is applied together with any command except a clear.
- R13: In a cycle with no strobe high, all four outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_line_i | input | 1 | Layout: 1 = two lines of 40, 0 = one line of 80 |
| ld_dd_i | input | 1 | Load pointer, select text memory |
| ld_cg_i | input | 1 | Load pointer, select glyph memory |
| ld_addr_i | input | 7 | Address for either load |
| acc_i | input | 1 | A data read or write has taken place |
| mode_i | input | 1 | Entry mode write strobe |
| mode_inc_i | input | 1 | Direction written by mode_i (1 = up) |
| move_i | input | 1 | Cursor or display move strobe |
| move_disp_i | input | 1 | 1 = shift display, 0 = move cursor |
| move_right_i | input | 1 | Direction of the move (1 = right) |
| home_i | input | 1 | Return to home |
| clear_i | input | 1 | Clear command |
| addr_o | output | 7 | Current RAM address |
| cg_sel_o | output | 1 | 1 = glyph memory, 0 = text memory |
| inc_o | output | 1 | Current step direction |
| shift_o | output | 7 | Display scroll offset |

## Verification
The bench sweeps every text-memory cell in both directions and in both layouts against an index-based model. A counter that missed the 27h/40h or 67h/00h jumps would land in the unused hole or stop short of the line end, and a one-line counter that failed to wrap would run past 4Fh. Offset sweeps go past a full line length in each layout, so a scroll that does not wrap per line, or that wraps at the wrong length, gives a value out of range. Collision cycles catch a clear that gives way to a simultaneous mode write, a load that loses to a data step, and a display shift that still moves the pointer.

// File: rtl/ram_addr_ctr_pkg.sv
package ram_addr_ctr_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_STEP  = 3'd1,
    OP_MOVE  = 3'd2,
    OP_LDCG  = 3'd3,
    OP_LDDD  = 3'd4,
    OP_HOME  = 3'd5,
    OP_CLEAR = 3'd6
  } ctr_op_e;
endpackage

// File: rtl/ram_addr_ctr_rst_sync.sv
module ram_addr_ctr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ram_addr_ctr_arb.sv
module ram_addr_ctr_arb
  import ram_addr_ctr_pkg::*;
(
  input  logic    clear_i,
  input  logic    home_i,
  input  logic    ld_dd_i,
  input  logic    ld_cg_i,
  input  logic    move_i,
  input  logic    acc_i,
  output ctr_op_e op_o
);
  always_comb begin
    if      (clear_i) op_o = OP_CLEAR;
    else if (home_i)  op_o = OP_HOME;
    else if (ld_dd_i) op_o = OP_LDDD;
    else if (ld_cg_i) op_o = OP_LDCG;
    else if (move_i)  op_o = OP_MOVE;
    else if (acc_i)   op_o = OP_STEP;
    else              op_o = OP_IDLE;
  end
endmodule

// File: rtl/ram_addr_ctr_step.sv
module ram_addr_ctr_step #(
  parameter int ADDR_W     = 7,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              two_line_i,
  input  logic              cg_i,
  input  logic              up_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ZERO     = '0;
  localparam logic [ADDR_W-1:0] L1_LAST  = ADDR_W'(2*LINE_LEN - 1);
  localparam logic [ADDR_W-1:0] A_LAST   = ADDR_W'(LINE_LEN - 1);
  localparam logic [ADDR_W-1:0] B_FIRST  = ADDR_W'(LINE2_BASE);
  localparam logic [ADDR_W-1:0] B_LAST   = ADDR_W'(LINE2_BASE + LINE_LEN - 1);

  always_comb begin
    addr_o = up_i ? addr_i + ONE : addr_i - ONE;
    if (!cg_i) begin
      if (two_line_i) begin
        if (up_i) begin
          if (addr_i == A_LAST)      addr_o = B_FIRST;
          else if (addr_i == B_LAST) addr_o = ZERO;
        end else begin
          if (addr_i == B_FIRST)     addr_o = A_LAST;
          else if (addr_i == ZERO)   addr_o = B_LAST;
        end
      end else begin
        if (up_i && addr_i == L1_LAST)   addr_o = ZERO;
        else if (!up_i && addr_i == ZERO) addr_o = L1_LAST;
      end
    end
  end
endmodule

// File: rtl/ram_addr_ctr_scroll.sv
module ram_addr_ctr_scroll #(
  parameter int LINE_LEN = 40,
  parameter int OFF_W    = $clog2(2*LINE_LEN)
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic             two_line_i,
  input  logic             up_i,
  output logic [OFF_W-1:0] off_o
);
  localparam logic [OFF_W-1:0] ONE      = OFF_W'(1);
  localparam logic [OFF_W-1:0] LAST_TWO = OFF_W'(LINE_LEN - 1);
  localparam logic [OFF_W-1:0] LAST_ONE = OFF_W'(2*LINE_LEN - 1);

  logic [OFF_W-1:0] last;

  always_comb begin
    last = two_line_i ? LAST_TWO : LAST_ONE;
    if (up_i) off_o = (off_i >= last) ? '0 : off_i + ONE;
    else      off_o = (off_i == '0 || off_i > last) ? last : off_i - ONE;
  end
endmodule

// File: rtl/ram_addr_ctr.sv
module ram_addr_ctr
  import ram_addr_ctr_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            two_line_i,
  input  logic                            ld_dd_i,
  input  logic                            ld_cg_i,
  input  logic [ADDR_W-1:0]               ld_addr_i,
  input  logic                            acc_i,
  input  logic                            mode_i,
  input  logic                            mode_inc_i,
  input  logic                            move_i,
  input  logic                            move_disp_i,
  input  logic                            move_right_i,
  input  logic                            home_i,
  input  logic                            clear_i,
  output logic [ADDR_W-1:0]               addr_o,
  output logic                            cg_sel_o,
  output logic                            inc_o,
  output logic [$clog2(2*LINE_LEN)-1:0]   shift_o
);
  localparam int OFF_W = $clog2(2*LINE_LEN);

  logic              rst_q_n;
  ctr_op_e           op;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_step;
  logic              cg_q, cg_d;
  logic              inc_q, inc_d;
  logic [OFF_W-1:0]  off_q, off_d, off_step;
  logic              step_up;
  logic              upd_en;

  ram_addr_ctr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  ram_addr_ctr_arb u_arb (
    .clear_i (clear_i),
    .home_i  (home_i),
    .ld_dd_i (ld_dd_i),
    .ld_cg_i (ld_cg_i),
    .move_i  (move_i),
    .acc_i   (acc_i),
    .op_o    (op)
  );

  assign step_up = (op == OP_MOVE) ? move_right_i : inc_q;

  ram_addr_ctr_step #(
    .ADDR_W(ADDR_W), .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE)
  ) u_step (
    .addr_i     (addr_q),
    .two_line_i (two_line_i),
    .cg_i       (cg_q),
    .up_i       (step_up),
    .addr_o     (addr_step)
  );

  ram_addr_ctr_scroll #(.LINE_LEN(LINE_LEN), .OFF_W(OFF_W)) u_scroll (
    .off_i      (off_q),
    .two_line_i (two_line_i),
    .up_i       (!move_right_i),
    .off_o      (off_step)
  );

  assign upd_en = (op != OP_IDLE) || mode_i;

  always_comb begin
    addr_d = addr_q;
    cg_d   = cg_q;
    off_d  = off_q;
    inc_d  = mode_i ? mode_inc_i : inc_q;
    unique case (op)
      OP_CLEAR: begin
        addr_d = '0; cg_d = 1'b0; off_d = '0; inc_d = 1'b1;
      end
      OP_HOME: begin
        addr_d = '0; cg_d = 1'b0; off_d = '0;
      end
      OP_LDDD: begin
        addr_d = ld_addr_i; cg_d = 1'b0;
      end
      OP_LDCG: begin
        addr_d = ld_addr_i; cg_d = 1'b1;
      end
      OP_MOVE: begin
        if (move_disp_i) off_d  = off_step;
        else             addr_d = addr_step;
      end
      OP_STEP: addr_d = addr_step;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_q <= '0;
      cg_q   <= 1'b0;
      inc_q  <= 1'b1;
      off_q  <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      cg_q   <= cg_d;
      inc_q  <= inc_d;
      off_q  <= off_d;
    end
  end

  assign addr_o   = addr_q;
  assign cg_sel_o = cg_q;
  assign inc_o    = inc_q;
  assign shift_o  = off_q;
endmodule

// File: rtl/ram_addr_ctr_chk.sv
module ram_addr_ctr_chk #(
  parameter int ADDR_W     = 7,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64,
  parameter int OFF_W      = $clog2(2*LINE_LEN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              two_line_i,
  input logic              ld_dd_i,
  input logic              ld_cg_i,
  input logic [ADDR_W-1:0] ld_addr_i,
  input logic              acc_i,
  input logic              mode_i,
  input logic              move_i,
  input logic              move_disp_i,
  input logic              home_i,
  input logic              clear_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              cg_sel_o,
  input logic              inc_o,
  input logic [OFF_W-1:0]  shift_o
);
  logic above_move, only_acc, quiet;
  assign above_move = clear_i | home_i | ld_dd_i | ld_cg_i;
  assign only_acc   = acc_i & ~above_move & ~move_i;
  assign quiet      = ~(above_move | move_i | acc_i | mode_i);

  // R11
  clear_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (addr_o == '0 && shift_o == '0 && inc_o && !cg_sel_o));

  // R10
  home_keep_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (home_i && !clear_i && !mode_i) |=>
      (addr_o == '0 && shift_o == '0 && !cg_sel_o && inc_o == $past(inc_o)));

  // R2
  load_text_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_dd_i && !clear_i && !home_i) |=> (addr_o == $past(ld_addr_i) && !cg_sel_o));

  // R3
  load_glyph_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cg_i && !ld_dd_i && !clear_i && !home_i) |=>
      (addr_o == $past(ld_addr_i) && cg_sel_o));

  // R9
  scroll_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (move_i && move_disp_i && !above_move) |=> ($stable(addr_o) && $stable(cg_sel_o)));

  // R6
  row_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (only_acc && two_line_i && !cg_sel_o && inc_o && addr_o == ADDR_W'(LINE_LEN-1))
      |=> (addr_o == ADDR_W'(LINE2_BASE)));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> ($stable(addr_o) && $stable(shift_o) && $stable(cg_sel_o) && $stable(inc_o)));
endmodule

bind ram_addr_ctr ram_addr_ctr_chk #(
  .ADDR_W(ADDR_W), .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE), .OFF_W(OFF_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .two_line_i   (two_line_i),
  .ld_dd_i      (ld_dd_i),
  .ld_cg_i      (ld_cg_i),
  .ld_addr_i    (ld_addr_i),
  .acc_i        (acc_i),
  .mode_i       (mode_i),
  .move_i       (move_i),
  .move_disp_i  (move_disp_i),
  .home_i       (home_i),
  .clear_i      (clear_i),
  .addr_o       (addr_o),
  .cg_sel_o     (cg_sel_o),
  .inc_o        (inc_o),
  .shift_o      (shift_o)
);

// File: tb/ram_addr_ctr_bench.sv
`timescale 1ns/1ps
module ram_addr_ctr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       two_line_i = 1'b0;
  logic       ld_dd_i = 1'b0, ld_cg_i = 1'b0;
  logic [6:0] ld_addr_i = '0;
  logic       acc_i = 1'b0, mode_i = 1'b0, mode_inc_i = 1'b0;
  logic       move_i = 1'b0, move_disp_i = 1'b0, move_right_i = 1'b0;
  logic       home_i = 1'b0, clear_i = 1'b0;
  logic [6:0] addr_o;
  logic       cg_sel_o, inc_o;
  logic [6:0] shift_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ram_addr_ctr u_ram_addr_ctr (
    .clk(clk), .rst_n(rst_n), .two_line_i(two_line_i),
    .ld_dd_i(ld_dd_i), .ld_cg_i(ld_cg_i), .ld_addr_i(ld_addr_i),
    .acc_i(acc_i), .mode_i(mode_i), .mode_inc_i(mode_inc_i),
    .move_i(move_i), .move_disp_i(move_disp_i), .move_right_i(move_right_i),
    .home_i(home_i), .clear_i(clear_i),
    .addr_o(addr_o), .cg_sel_o(cg_sel_o), .inc_o(inc_o), .shift_o(shift_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Wait one negedge, then drop all strobes; outputs now show the edge.
  task automatic tick();
    @(negedge clk);
    ld_dd_i = 0; ld_cg_i = 0; acc_i = 0; mode_i = 0;
    move_i = 0; home_i = 0; clear_i = 0;
  endtask

  // Two-line cell index (0..79) to address.
  function automatic int two_addr(int p);
    return (p < 40) ? p : 64 + (p - 40);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int p;
    repeat (5) @(negedge clk);
    chk("R1 addr in reset", addr_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 addr", addr_o, 0);
    chk("R1 sel", cg_sel_o, 0);
    chk("R1 dir", inc_o, 1);
    chk("R1 shift", shift_o, 0);

    // R4 R6: two-line full sweep up then down
    two_line_i = 1;
    ld_dd_i = 1; ld_addr_i = 7'h00; tick();
    chk("R2 load text", addr_o, 0);
    mode_i = 1; mode_inc_i = 1; tick();
    chk("R4 dir up", inc_o, 1);
    p = 0;
    for (int k = 0; k < 82; k++) begin
      acc_i = 1; tick();
      p = (p + 1) % 80;
      chk("R6 two-line up", addr_o, two_addr(p));
    end
    mode_i = 1; mode_inc_i = 0; tick();
    chk("R4 dir down", inc_o, 0);
    for (int k = 0; k < 82; k++) begin
      acc_i = 1; tick();
      p = (p + 79) % 80;
      chk("R6 two-line down", addr_o, two_addr(p));
    end

    // R5: one-line sweeps
    two_line_i = 0;
    ld_dd_i = 1; ld_addr_i = 7'h4D; tick();
    mode_i = 1; mode_inc_i = 1; tick();
    p = 77;
    for (int k = 0; k < 162; k++) begin
      acc_i = 1; tick();
      p = (p + 1) % 80;
      chk("R5 one-line up", addr_o, p);
    end
    mode_i = 1; mode_inc_i = 0; tick();
    for (int k = 0; k < 162; k++) begin
      acc_i = 1; tick();
      p = (p + 79) % 80;
      chk("R5 one-line down", addr_o, p);
    end

    // R3 R7: glyph memory ignores layout
    two_line_i = 1;
    ld_cg_i = 1; ld_addr_i = 7'h25; tick();
    chk("R3 load glyph addr", addr_o, 37);
    chk("R3 glyph sel", cg_sel_o, 1);
    mode_i = 1; mode_inc_i = 1; tick();
    p = 37;
    for (int k = 0; k < 130; k++) begin
      acc_i = 1; tick();
      p = (p + 1) % 128;
      chk("R7 glyph up", addr_o, p);
    end
    mode_i = 1; mode_inc_i = 0; tick();
    for (int k = 0; k < 130; k++) begin
      acc_i = 1; tick();
      p = (p + 127) % 128;
      chk("R7 glyph down", addr_o, p);
    end

    // R8: cursor moves use line rules, leave offset
    ld_dd_i = 1; ld_addr_i = 7'h27; tick();
    move_i = 1; move_disp_i = 0; move_right_i = 1; tick();
    chk("R8 right across row", addr_o, 64);
    chk("R8 offset kept", shift_o, 0);
    move_i = 1; move_disp_i = 0; move_right_i = 0; tick();
    chk("R8 left across row", addr_o, 39);
    two_line_i = 0;
    ld_dd_i = 1; ld_addr_i = 7'h00; tick();
    move_i = 1; move_disp_i = 0; move_right_i = 0; tick();
    chk("R8 left one-line wrap", addr_o, 79);

    // R9: display shift wraps per line length
    two_line_i = 1;
    ld_dd_i = 1; ld_addr_i = 7'h42; tick();
    p = 0;
    for (int k = 0; k < 43; k++) begin
      move_i = 1; move_disp_i = 1; move_right_i = 0; tick();
      p = (p + 1) % 40;
      chk("R9 shift left two-line", shift_o, p);
      chk("R9 pointer kept", addr_o, 66);
    end
    for (int k = 0; k < 5; k++) begin
      move_i = 1; move_disp_i = 1; move_right_i = 1; tick();
      p = (p + 39) % 40;
      chk("R9 shift right two-line", shift_o, p);
    end
    home_i = 1; tick();
    two_line_i = 0;
    p = 0;
    for (int k = 0; k < 82; k++) begin
      move_i = 1; move_disp_i = 1; move_right_i = 0; tick();
      p = (p + 1) % 80;
      chk("R9 shift left one-line", shift_o, p);
    end
    move_i = 1; move_disp_i = 1; move_right_i = 1; tick();
    move_i = 1; move_disp_i = 1; move_right_i = 1; tick();
    move_i = 1; move_disp_i = 1; move_right_i = 1; tick();
    chk("R9 shift right one-line wrap", shift_o, 79);

    // R10: home keeps direction
    mode_i = 1; mode_inc_i = 0; tick();
    ld_cg_i = 1; ld_addr_i = 7'h11; tick();
    home_i = 1; tick();
    chk("R10 addr", addr_o, 0);
    chk("R10 shift", shift_o, 0);
    chk("R10 sel", cg_sel_o, 0);
    chk("R10 dir kept", inc_o, 0);

    // R11 R12: clear beats a same-cycle mode write
    move_i = 1; move_disp_i = 1; move_right_i = 0; tick();
    ld_dd_i = 1; ld_addr_i = 7'h30; tick();
    clear_i = 1; mode_i = 1; mode_inc_i = 0; tick();
    chk("R11 addr", addr_o, 0);
    chk("R11 shift", shift_o, 0);
    chk("R11 dir up despite mode", inc_o, 1);

    // R12: priority between commands
    ld_dd_i = 1; acc_i = 1; ld_addr_i = 7'h10; tick();
    chk("R12 load beats step", addr_o, 16);
    ld_dd_i = 1; ld_cg_i = 1; ld_addr_i = 7'h12; tick();
    chk("R12 text load beats glyph", cg_sel_o, 0);
    move_i = 1; move_disp_i = 0; move_right_i = 0; acc_i = 1; tick();
    chk("R12 move beats step", addr_o, 17);
    home_i = 1; ld_dd_i = 1; ld_addr_i = 7'h20; mode_i = 1; mode_inc_i = 0; tick();
    chk("R12 home beats load", addr_o, 0);
    chk("R12 mode rides along", inc_o, 0);

    // R13: idle holds
    ld_dd_i = 1; ld_addr_i = 7'h4A; tick();
    move_i = 1; move_disp_i = 1; move_right_i = 0; tick();
    ld_addr_i = 7'h05; mode_inc_i = 1; move_right_i = 1;
    repeat (6) tick();
    chk("R13 addr held", addr_o, 74);
    chk("R13 shift held", shift_o, 1);
    chk("R13 dir held", inc_o, 0);
    chk("R13 sel held", cg_sel_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule